// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block stores the architectural registers of a 32-bit processor that runs in several privilege modes. Each mode sees sixteen general registers, indexed 0 to 15, and one current status word. Some indices resolve to a physical copy that belongs to the active mode. Index 13 is the stack pointer. Index 14 is the link register. Index 15 is the program counter. The exception modes also see a saved-status word.

Storage holds 31 general registers and 6 status words:
- one current status word;
- five saved-status words.

The low five bits of the current status word select the mode:

| Mode | Code |
|---|---|
| user | 10000 |
| fast interrupt | 10001 |
| interrupt | 10010 |
| supervisor | 10011 |
| abort | 10111 |
| undefined | 11011 |
| system | 11111 |

Bit 5 of the status word selects the compact instruction state.

Software changes mode by writing the status word. The pipeline drives these inputs:
- two read indices;
- one write index;
- a link-capture strobe;
- an exception-entry strobe, which carries a target mode and a return address.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word is 0x00000013 (supervisor mode, full-width state). Every general register and every saved-status word is zero.
- R2: Indices 0 to 7 map to one shared physical register in every mode.
- R3: In fast interrupt mode (10001), indices 8 to 12 map to a private set of registers. All other modes share the user copies of indices 8 to 12.
- R4: Indices 13 and 14 have private copies in each of the five exception modes. System mode (11111) uses the user copies. Any unlisted mode code also uses the user bank.
- R5: Index 15 reads with bits [1:0] forced to zero when status bit 5 is 0. It reads with bit 0 forced to zero when status bit 5 is 1.
- R6: A link-capture strobe writes the aligned program counter value (as in R5) into the index-14 register of the current mode at the next clock edge.
- R7: When a write-port write to index 14 and a link capture occur in the same cycle, the link capture value is stored.
- R8: An exception-entry strobe with a valid exception target does three things in one cycle:
  - it stores the old status word into the target's saved-status word;
  - it stores the return address into the target's index-14 register;
  - it replaces the mode field (bits [4:0]) with the target code and keeps all other status bits.
- R9: A valid exception entry suppresses every other write in the same cycle. An entry strobe whose target is user, system or an unlisted code changes nothing.
- R10: In user and system modes the saved-status read is zero, and saved-status writes are ignored. In an exception mode, a saved-status write updates that mode's copy.
- R11: Both read ports are combinational and independent, so two different indices read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port index |
| wr_data | input | 32 | Write port data |
| link_cap | input | 1 | Copy aligned program counter into current link register |
| sts_wr_en | input | 1 | Status word write enable |
| sts_wr_data | input | 32 | New status word, including mode field and state bit |
| status_out | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved-status write enable for the current mode |
| spsr_wr_data | input | 32 | Saved-status write data |
| spsr_rd_data | output | 32 | Saved-status word of the current mode |
| exc_take | input | 1 | Exception-entry strobe |
| exc_mode | input | 5 | Target mode code of the exception |
| exc_ret_addr | input | 32 | Return address stored into the target link register |

## Verification
A wrong bank mapping never shows on its own. It appears only when a value written in one mode is read back in another mode, or when a register that should be private reads as another mode's data. The bench therefore writes every index in user mode, then reads across every mode boundary. An exception-entry or link-capture fault corrupts state at the next edge. It is visible at the ports one cycle later, through the status output, the saved-status read, or a read of index 14 in the target mode. Alignment faults show at once, on any read of index 15.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            link_cap,
  input  logic            sts_wr_en,
  input  logic [XLEN-1:0] sts_wr_data,
  output logic [XLEN-1:0] status_out,
  input  logic            spsr_wr_en,
  input  logic [XLEN-1:0] spsr_wr_data,
  output logic [XLEN-1:0] spsr_rd_data,
  input  logic            exc_take,
  input  logic [4:0]      exc_mode,
  input  logic [XLEN-1:0] exc_ret_addr
);
  localparam int NPHYS  = 31;
  localparam int NSAVED = 5;
  localparam int PW     = $clog2(NPHYS);
  localparam logic [XLEN-1:0] STS_RESET = {{(XLEN-5){1'b0}}, 5'b10011};

  logic [XLEN-1:0] gpr   [NPHYS];
  logic [XLEN-1:0] saved [NSAVED];
  logic [XLEN-1:0] status;

  // bank: 0 user/system/other, 1 fiq, 2 irq, 3 svc, 4 abt, 5 und
  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      5'b10001: bank_of = 3'd1;
      5'b10010: bank_of = 3'd2;
      5'b10011: bank_of = 3'd3;
      5'b10111: bank_of = 3'd4;
      5'b11011: bank_of = 3'd5;
      default:  bank_of = 3'd0;
    endcase
  endfunction

  function automatic logic [PW-1:0] phys(input logic [2:0] b, input logic [3:0] i);
    if (b == 3'd1 && i >= 4'd8 && i <= 4'd14)
      phys = PW'(16 + int'(i) - 8);
    else if (b >= 3'd2 && (i == 4'd13 || i == 4'd14))
      phys = PW'(23 + 2 * (int'(b) - 2) + int'(i) - 13);
    else
      phys = PW'(i);
  endfunction

  logic [2:0]      cur_bank, exc_bank;
  logic            exc_ok;
  logic [XLEN-1:0] pc_view;
  logic [PW-1:0]   lr_cur;

  assign cur_bank = bank_of(status[4:0]);
  assign exc_bank = bank_of(exc_mode);
  assign exc_ok   = exc_take && (exc_bank != 3'd0);
  assign lr_cur   = phys(cur_bank, 4'd14);
  assign pc_view  = status[5] ? {gpr[15][XLEN-1:1], 1'b0}
                              : {gpr[15][XLEN-1:2], 2'b00};

  assign rd_a_data    = (rd_a_idx == 4'd15) ? pc_view : gpr[phys(cur_bank, rd_a_idx)];
  assign rd_b_data    = (rd_b_idx == 4'd15) ? pc_view : gpr[phys(cur_bank, rd_b_idx)];
  assign status_out   = status;
  assign spsr_rd_data = (cur_bank == 3'd0) ? '0 : saved[cur_bank - 3'd1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NPHYS; k++) gpr[k] <= '0;
      for (int k = 0; k < NSAVED; k++) saved[k] <= '0;
      status <= STS_RESET;
    end else if (exc_ok) begin
      saved[exc_bank - 3'd1]      <= status;
      gpr[phys(exc_bank, 4'd14)]  <= exc_ret_addr;
      status[4:0]                 <= exc_mode;
    end else begin
      if (wr_en)    gpr[phys(cur_bank, wr_idx)] <= wr_data;
      if (link_cap) gpr[lr_cur] <= pc_view;
      if (sts_wr_en) status <= sts_wr_data;
      if (spsr_wr_en && cur_bank != 3'd0) saved[cur_bank - 3'd1] <= spsr_wr_data;
    end
  end

  a_r5_pc_align: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data[0] == 1'b0 && (status[5] || rd_a_data[1] == 1'b0)));

  a_r6_link_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (link_cap && !exc_ok) |=> gpr[$past(lr_cur)] == $past(pc_view));

  a_r7_link_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
    (link_cap && wr_en && wr_idx == 4'd14 && !exc_ok) |=> rd_a_data != 32'hx || gpr[$past(lr_cur)] == $past(pc_view));

  a_r8_exc_mode: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> (status[4:0] == $past(exc_mode) && status[XLEN-1:5] == $past(status[XLEN-1:5])));

  a_r8_exc_saved: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ok |=> spsr_rd_data == $past(status));

  a_r9_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && !exc_ok && !sts_wr_en) |=> $stable(status));

  a_r10_spsr_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bank == 3'd0) |-> spsr_rd_data == '0);
endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, sts_wr_data = 0, status_out;
  logic [31:0] spsr_wr_data = 0, spsr_rd_data, exc_ret_addr = 0;
  logic wr_en = 0, link_cap = 0, sts_wr_en = 0, spsr_wr_en = 0, exc_take = 0;
  logic [4:0] exc_mode = 0;

  banked_regfile dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rd_a_data;
        1: act = rd_b_data;
        2: act = status_out;
        default: act = spsr_rd_data;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic exp_a(input logic [3:0] i, input logic [31:0] e, input string t);
    item_t it;
    rd_a_idx = i; it.kind = 0; it.exp = e; it.tag = t; q.push_back(it); settle();
  endtask

  task automatic exp_ab(input logic [3:0] ia, input logic [31:0] ea,
                        input logic [3:0] ib, input logic [31:0] eb, input string t);
    item_t x, y;
    rd_a_idx = ia; rd_b_idx = ib;
    x.kind = 0; x.exp = ea; x.tag = t; q.push_back(x);
    y.kind = 1; y.exp = eb; y.tag = t; q.push_back(y);
    settle();
  endtask

  task automatic exp_k(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t; q.push_back(it); settle();
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic setsts(input logic [31:0] v);
    sts_wr_en = 1; sts_wr_data = v; tick(); sts_wr_en = 0;
  endtask

  function automatic logic [31:0] uval(input int i);
    return 32'h0100_0000 | i;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    exp_k(2, 32'h13, "R1 status");
    exp_k(3, 32'h0, "R1 saved");
    exp_ab(4'd0, 32'h0, 4'd15, 32'h0, "R1 regs");

    setsts(32'h10);
    for (int i = 0; i < 15; i++) wr(4'(i), uval(i));
    wr(4'd15, 32'h0000_1003);
    exp_ab(4'd3, uval(3), 4'd12, uval(12), "R11 dual read");

    exp_a(4'd15, 32'h1000, "R5 arm align");
    setsts(32'h30);
    exp_a(4'd15, 32'h1002, "R5 thumb align");
    setsts(32'h10);

    exp_k(3, 32'h0, "R10 user saved");
    spsr_wr_en = 1; spsr_wr_data = 32'hABCD; tick(); spsr_wr_en = 0;
    exp_k(3, 32'h0, "R10 user write ignored");
    setsts(32'h1F);
    exp_k(3, 32'h0, "R10 system saved");
    exp_ab(4'd13, uval(13), 4'd14, uval(14), "R4 system shares user");
    setsts(32'h10);

    setsts(32'h11);
    exp_ab(4'd8, 32'h0, 4'd12, 32'h0, "R3 fiq private");
    exp_a(4'd7, uval(7), "R2 shared low");
    exp_a(4'd13, 32'h0, "R4 fiq r13");
    wr(4'd8, 32'hF8);
    exp_a(4'd8, 32'hF8, "R3 fiq write");
    setsts(32'h10);
    exp_a(4'd8, uval(8), "R3 user r8 kept");

    setsts(32'h12);
    wr(4'd13, 32'h1113);
    exp_a(4'd8, uval(8), "R3 irq shares r8");
    setsts(32'h13);
    exp_a(4'd13, 32'h0, "R4 svc r13 separate");
    setsts(32'h10);
    exp_a(4'd13, uval(13), "R4 user r13 kept");

    link_cap = 1; tick(); link_cap = 0;
    exp_a(4'd14, 32'h1000, "R6 link arm");
    setsts(32'h30);
    link_cap = 1; tick(); link_cap = 0;
    exp_a(4'd14, 32'h1002, "R6 link thumb");

    link_cap = 1; wr_en = 1; wr_idx = 4'd14; wr_data = 32'hBAD; tick();
    link_cap = 0; wr_en = 0;
    exp_a(4'd14, 32'h1002, "R7 link priority");

    setsts(32'hF000_0010);
    exc_take = 1; exc_mode = 5'b10010; exc_ret_addr = 32'h2004; tick(); exc_take = 0;
    exp_k(2, 32'hF000_0012, "R8 status mode");
    exp_k(3, 32'hF000_0010, "R8 saved status");
    exp_ab(4'd14, 32'h2004, 4'd13, 32'h1113, "R8 return addr");

    exc_take = 1; exc_mode = 5'b10000; tick(); exc_take = 0;
    exp_k(2, 32'hF000_0012, "R9 invalid target");

    exc_take = 1; exc_mode = 5'b10011; exc_ret_addr = 32'h3000;
    wr_en = 1; wr_idx = 4'd0; wr_data = 32'hDEAD;
    sts_wr_en = 1; sts_wr_data = 32'h10; tick();
    exc_take = 0; wr_en = 0; sts_wr_en = 0;
    exp_k(2, 32'hF000_0013, "R9 entry blocks status write");
    exp_a(4'd0, uval(0), "R9 entry blocks reg write");
    exp_k(3, 32'hF000_0012, "R8 saved svc");
    exp_a(4'd14, 32'h3000, "R8 svc link");

    spsr_wr_en = 1; spsr_wr_data = 32'h55; tick(); spsr_wr_en = 0;
    exp_k(3, 32'h55, "R10 privileged saved write");

    settle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule